// File: doc/BRIEF.md
# Line-Oriented Hex Command Monitor

This block is a small command interpreter placed between a byte-wide serial receive and transmit path and two consumers: a data stack and an execute request port. It works on one entry per line. At the start of each entry it moves the terminal to a fresh line and prints a prompt. It then reads a one-letter selector followed by hexadecimal digits. At the end of the line it either pushes the parsed value onto the data stack or asks for the routine at the parsed address to be executed.

The selector letter `W` (or `w`) means execute. Any other letter means push, with `N` being the usual choice. Digits are read in hexadecimal, and the accumulated value wraps to its parameterised width. Characters that are not digits are skipped without comment. A pushed value stays on the stack for a later executed routine to consume. While an execute request is outstanding, the monitor holds the request and discards any incoming bytes until the done handshake arrives.

The controller has eight states:
- `S_BOOT` is the reset state.
- `S_NL_CR`, `S_NL_LF` and `S_PROMPT` each send one character of the new-line-and-prompt sequence.
- `S_SELECT` waits for the selector.
- `S_DIGITS` collects the digits.
- `S_PUSH` presents the value to the stack for one cycle.
- `S_EXEC` holds the execute request.

Its transitions are:
- `S_BOOT→S_NL_CR→S_NL_LF→S_PROMPT→S_SELECT`, always.
- `S_SELECT→S_NL_CR` when the first byte is a terminator.
- `S_SELECT→S_DIGITS` on any other byte.
- `S_DIGITS→S_PUSH` or `S_DIGITS→S_EXEC` on a terminator, chosen by the selector.
- `S_PUSH→S_NL_CR`, always.
- `S_EXEC→S_NL_CR` when the done handshake is seen.

Top module: `hex_monitor`

## Requirements
- R1: After reset is released, the monitor emits carriage return 0x0D, line feed 0x0A and prompt 0x3E on `tx_data` with `tx_valid` high on three consecutive cycles. It then waits for input, and the same three bytes begin every later entry. While reset is held, `tx_valid`, `push_valid` and `exec_valid` are all low.
- R2: A first byte of 0x57 (`W`) or 0x77 (`w`) selects execute. Any other first byte that is not a terminator selects push.
- R3: Each hex digit (0x30–0x39, 0x41–0x46, 0x61–0x66) after the selector updates the value to (value·16 + digit) mod 2^16. Only the last four digits therefore survive, and a line with no digits yields 0.
- R4: Bytes after the selector that are not hex digits or terminators are skipped. They leave the value unchanged and produce no output of any kind.
- R5: A line ends at 0x0D or 0x00. On a push line, `push_valid` is high for exactly one cycle carrying the value, and the new-line sequence starts on the next cycle.
- R6: On an execute line, `exec_valid` stays high with a stable `exec_addr` equal to the value until `exec_done` is sampled high. The new-line sequence starts on the next cycle.
- R7: Bytes received while an execute request is pending are dropped. They cause no push, no transmit and no change to the next entry.
- R8: A line whose first byte is a terminator causes neither push nor execute. The prompt sequence is simply reissued.
- R9: At most one of `tx_valid`, `push_valid` and `exec_valid` is high in any cycle, and each line produces at most one push or one execute request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8 | Received character |
| rx_valid | input | 1 | `rx_data` holds a new character this cycle |
| tx_data | output | 8 | Character to transmit |
| tx_valid | output | 1 | `tx_data` is valid this cycle |
| push_data | output | 16 | Value to push onto the data stack |
| push_valid | output | 1 | Push strobe, one cycle |
| exec_addr | output | 16 | Address of the routine to execute |
| exec_valid | output | 1 | Execute request, held until done |
| exec_done | input | 1 | The executed routine has finished |

## Verification
The embedded properties check several behaviours on every cycle:
- the order of the prompt characters;
- the one-cycle width of the push strobe and the return to the new-line sequence after it;
- that the execute request and its address are held steady until the done handshake;
- that the controller stays in `S_EXEC` when a byte arrives without done;
- the mutual exclusion of the three output strobes.

The actual parsed values can only be shown by the bench's scenarios. These cover:
- an exhaustive sweep of single digits in both cases;
- a sweep of 64 four-digit words that mixes selectors and both terminators;
- wrap-around on long entries and skipped junk characters;
- empty and digit-less lines;
- a long execute wait with bytes injected while the request is pending.

// File: rtl/mon_pkg.sv
package mon_pkg;

    localparam int CHAR_W = 8;

    localparam logic [CHAR_W-1:0] CH_NUL = 8'h00;
    localparam logic [CHAR_W-1:0] CH_LF  = 8'h0A;
    localparam logic [CHAR_W-1:0] CH_CR  = 8'h0D;

    typedef enum logic [2:0] {
        S_BOOT   = 3'd0,
        S_NL_CR  = 3'd1,
        S_NL_LF  = 3'd2,
        S_PROMPT = 3'd3,
        S_SELECT = 3'd4,
        S_DIGITS = 3'd5,
        S_PUSH   = 3'd6,
        S_EXEC   = 3'd7
    } mon_state_e;

endpackage

// File: rtl/mon_char_class.sv
module mon_char_class
    import mon_pkg::*;
#(
    parameter logic [CHAR_W-1:0] EXEC_CH = 8'h57
) (
    input  logic [CHAR_W-1:0] ch,
    output logic              is_hex,
    output logic [3:0]        nib,
    output logic              is_term,
    output logic              is_exec_sel
);

    localparam logic [CHAR_W-1:0] CASE_BIT = 8'h20;
    localparam logic [CHAR_W-1:0] EXEC_LC  = EXEC_CH | CASE_BIT;

    logic [CHAR_W-1:0] folded;

    always_comb begin
        folded = ch | CASE_BIT;
        is_hex = 1'b0;
        nib    = 4'd0;
        if (ch >= 8'h30 && ch <= 8'h39) begin
            is_hex = 1'b1;
            nib    = ch[3:0];
        end else if (folded >= 8'h61 && folded <= 8'h66) begin
            is_hex = 1'b1;
            nib    = ch[3:0] + 4'd9;
        end
        is_term     = (ch == CH_CR) || (ch == CH_NUL);
        is_exec_sel = (ch == EXEC_CH) || (ch == EXEC_LC);
    end

endmodule

// File: rtl/mon_value_acc.sv
module mon_value_acc #(
    parameter int VALUE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               shift,
    input  logic [3:0]         nib,
    output logic [VALUE_W-1:0] value
);

    logic [VALUE_W-1:0] value_q;
    logic [VALUE_W-1:0] shifted;

    generate
        if (VALUE_W > 4) begin : g_wide
            assign shifted = {value_q[VALUE_W-5:0], nib};
        end else begin : g_nib
            assign shifted = nib[VALUE_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)      value_q <= '0;
        else if (clear)  value_q <= '0;
        else if (shift)  value_q <= shifted;
    end

    assign value = value_q;

    // R3: a new entry starts from zero
    p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (value == '0));

    // R4: with no digit strobe the value holds
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !shift) |=> $stable(value));

endmodule

// File: rtl/mon_seq.sv
module mon_seq
    import mon_pkg::*;
#(
    parameter logic [CHAR_W-1:0] PROMPT_CH = 8'h3E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              is_hex,
    input  logic              is_term,
    input  logic              is_exec_sel,
    input  logic              exec_done,
    output logic              acc_clear,
    output logic              acc_shift,
    output logic [CHAR_W-1:0] tx_data,
    output logic              tx_valid,
    output logic              push_valid,
    output logic              exec_valid
);

    mon_state_e state_q, state_d;
    logic       sel_exec_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_BOOT;
            sel_exec_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_SELECT && rx_valid && !is_term)
                sel_exec_q <= is_exec_sel;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_BOOT:   state_d = S_NL_CR;
            S_NL_CR:  state_d = S_NL_LF;
            S_NL_LF:  state_d = S_PROMPT;
            S_PROMPT: state_d = S_SELECT;
            S_SELECT: if (rx_valid) state_d = is_term ? S_NL_CR : S_DIGITS;
            S_DIGITS: if (rx_valid && is_term) state_d = sel_exec_q ? S_EXEC : S_PUSH;
            S_PUSH:   state_d = S_NL_CR;
            S_EXEC:   if (exec_done) state_d = S_NL_CR;
        endcase
    end

    // outputs
    always_comb begin
        tx_valid   = 1'b0;
        tx_data    = '0;
        push_valid = 1'b0;
        exec_valid = 1'b0;
        unique case (state_q)
            S_BOOT:   ;
            S_NL_CR:  begin tx_valid = 1'b1; tx_data = CH_CR;     end
            S_NL_LF:  begin tx_valid = 1'b1; tx_data = CH_LF;     end
            S_PROMPT: begin tx_valid = 1'b1; tx_data = PROMPT_CH; end
            S_SELECT: ;
            S_DIGITS: ;
            S_PUSH:   push_valid = 1'b1;
            S_EXEC:   exec_valid = 1'b1;
        endcase
        acc_clear = (state_q == S_SELECT) && rx_valid;
        acc_shift = (state_q == S_DIGITS) && rx_valid && is_hex;
    end

    // R1: prompt characters come out in order
    p_prompt_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_data == CH_CR) |=> (tx_valid && tx_data == CH_LF));
    p_prompt_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_data == CH_LF) |=> (tx_valid && tx_data == PROMPT_CH));

    // R7: bytes during a pending request do not move the controller
    p_exec_ignores_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EXEC && !exec_done) |=> (state_q == S_EXEC));

    // R5: push strobe lasts one cycle
    p_push_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |=> !push_valid);

endmodule

// File: rtl/hex_monitor.sv
module hex_monitor
    import mon_pkg::*;
#(
    parameter int                VALUE_W   = 16,
    parameter logic [CHAR_W-1:0] PROMPT_CH = 8'h3E,
    parameter logic [CHAR_W-1:0] EXEC_CH   = 8'h57
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         rx_data,
    input  logic               rx_valid,
    output logic [7:0]         tx_data,
    output logic               tx_valid,
    output logic [VALUE_W-1:0] push_data,
    output logic               push_valid,
    output logic [VALUE_W-1:0] exec_addr,
    output logic               exec_valid,
    input  logic               exec_done
);

    logic       is_hex, is_term, is_exec_sel;
    logic [3:0] nib;
    logic       acc_clear, acc_shift;
    logic [VALUE_W-1:0] value;

    mon_char_class #(.EXEC_CH(EXEC_CH)) u_class (
        .ch          (rx_data),
        .is_hex      (is_hex),
        .nib         (nib),
        .is_term     (is_term),
        .is_exec_sel (is_exec_sel)
    );

    mon_value_acc #(.VALUE_W(VALUE_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (acc_clear),
        .shift (acc_shift),
        .nib   (nib),
        .value (value)
    );

    mon_seq #(.PROMPT_CH(PROMPT_CH)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid    (rx_valid),
        .is_hex      (is_hex),
        .is_term     (is_term),
        .is_exec_sel (is_exec_sel),
        .exec_done   (exec_done),
        .acc_clear   (acc_clear),
        .acc_shift   (acc_shift),
        .tx_data     (tx_data),
        .tx_valid    (tx_valid),
        .push_valid  (push_valid),
        .exec_valid  (exec_valid)
    );

    assign push_data = value;
    assign exec_addr = value;

    // R9: strobes are mutually exclusive
    p_strobes_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_valid, push_valid, exec_valid}));

    // R6: request and address held until done
    p_exec_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && !exec_done) |=> (exec_valid && $stable(exec_addr)));

    // R6: done returns to the new-line sequence
    p_exec_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && exec_done) |=> (tx_valid && tx_data == CH_CR));

    // R5: push is followed by the new-line sequence
    p_push_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |=> (tx_valid && tx_data == CH_CR));

endmodule

// File: tb/hex_monitor_bench.sv
module hex_monitor_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_valid = 1'b0;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic [15:0] push_data;
    logic        push_valid;
    logic [15:0] exec_addr;
    logic        exec_valid;
    logic        exec_done = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit excl_bad = 1'b0;

    logic [7:0]  txq[$];
    logic [15:0] pushq[$];

    always #4 clk = ~clk;

    hex_monitor u_hex_monitor (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
        .tx_data(tx_data), .tx_valid(tx_valid), .push_data(push_data),
        .push_valid(push_valid), .exec_addr(exec_addr), .exec_valid(exec_valid),
        .exec_done(exec_done)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid)   txq.push_back(tx_data);
            if (push_valid) pushq.push_back(push_data);
            if ((32'(tx_valid) + 32'(push_valid) + 32'(exec_valid)) > 1) excl_bad = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_data  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic send_str(input string s);
        for (int i = 0; i < s.len(); i++) send_byte(s[i]);
    endtask

    task automatic wait_prompt(input string req);
        for (int k = 0; k < 40 && txq.size() < 3; k++) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(txq.size() == 3, req, txq.size(), 3);
        if (txq.size() == 3)
            chk(txq[0] == 8'h0D && txq[1] == 8'h0A && txq[2] == 8'h3E, req,
                {8'h0, txq[0], txq[1], txq[2]}, 32'h000D0A3E);
        txq.delete();
    endtask

    task automatic expect_push(input logic [15:0] exp, input string req);
        wait_prompt(req);
        chk(pushq.size() == 1, req, pushq.size(), 1);
        if (pushq.size() == 1) chk(pushq[0] == exp, req, pushq[0], exp);
        pushq.delete();
    endtask

    function automatic logic [7:0] hexc(input logic [3:0] n, input bit lower);
        if (n < 10) return 8'h30 + 8'(n);
        return (lower ? 8'h61 : 8'h41) + 8'(n) - 8'd10;
    endfunction

    task automatic run_exec(input logic [15:0] exp, input int hold, input string req);
        int k;
        k = 0;
        while (!exec_valid && k < 20) begin @(negedge clk); k++; end
        chk(exec_valid == 1'b1, req, exec_valid, 1);
        chk(exec_addr == exp, req, exec_addr, exp);
        for (int c = 0; c < hold; c++) begin
            @(negedge clk);
            chk(exec_valid && exec_addr == exp, "R6 hold", exec_addr, exp);
        end
        @(negedge clk);
        exec_done = 1'b1;
        @(negedge clk);
        exec_done = 1'b0;
        wait_prompt(req);
        chk(pushq.size() == 0, req, pushq.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  sel;
        repeat (3) @(negedge clk);
        chk(!tx_valid && !push_valid && !exec_valid, "R1 reset idle",
            {tx_valid, push_valid, exec_valid}, 0);
        rst_n = 1'b1;
        wait_prompt("R1 first prompt");

        // R3: every digit, both cases
        for (int d = 0; d < 16; d++) begin
            for (int lc = 0; lc < 2; lc++) begin
                send_byte("N");
                send_byte(hexc(4'(d), lc[0]));
                send_byte(8'h0D);
                expect_push(16'(d), "R3 single digit");
            end
        end

        // R2/R5: word sweep with varied selector and terminator
        for (int i = 0; i < 64; i++) begin
            v = 16'(i * 16'h2F5B) ^ 16'(i << 3);
            sel = (i % 3 == 0) ? 8'h4E : ((i % 3 == 1) ? 8'h6E : 8'h23);
            send_byte(sel);
            for (int n = 3; n >= 0; n--) send_byte(hexc(v[n*4 +: 4], i[0]));
            send_byte(i[1] ? 8'h00 : 8'h0D);
            expect_push(v, "R2 R5 sweep");
        end

        // R3: wrap on long entries
        send_str("N12345"); send_byte(8'h0D);
        expect_push(16'h2345, "R3 wrap five");
        send_str("NDEADBEEF"); send_byte(8'h0D);
        expect_push(16'hBEEF, "R3 wrap eight");
        send_str("N"); send_byte(8'h0D);
        expect_push(16'h0000, "R3 no digits");

        // R4: junk skipped
        send_str("NZ1G-2 x"); send_byte(8'h0D);
        expect_push(16'h0012, "R4 junk");

        // R8: empty lines
        send_byte(8'h0D);
        wait_prompt("R8 empty cr");
        chk(pushq.size() == 0 && !exec_valid, "R8 empty cr", pushq.size(), 0);
        send_byte(8'h00);
        wait_prompt("R8 empty nul");
        chk(pushq.size() == 0 && !exec_valid, "R8 empty nul", pushq.size(), 0);

        // R6/R7: execute held, bytes dropped while pending
        send_str("W1A2b"); send_byte(8'h0D);
        fork
            run_exec(16'h1A2B, 25, "R6 exec upper");
            begin
                repeat (4) @(negedge clk);
                send_str("N5"); send_byte(8'h0D);
            end
        join
        chk(txq.size() == 0, "R7 no tx from dropped", txq.size(), 0);
        send_str("N9"); send_byte(8'h0D);
        expect_push(16'h0009, "R7 next entry clean");

        // R2: lowercase selector, immediate done
        send_str("w00ff"); send_byte(8'h00);
        run_exec(16'h00FF, 0, "R2 exec lower");

        // R9: strobes exclusive throughout
        chk(!excl_bad, "R9 exclusive", excl_bad, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule